// File: doc/BRIEF.md
# Descriptor DMA Channel Control and Status Register File

This block is the software-facing register file of one descriptor-driven DMA channel. Software reads and writes 32-bit registers at word offsets. The control register is never written as a whole word. Each write carries a bit-enable mask in bits 31:16 and new bit values in bits 15:0. The block uses these to update the software-owned run and pause bits and the wake and flush request bits. It then derives the hardware-owned active bit from the result. Reading the control offset returns the channel status.

The block also holds the descriptor command pointer and three condition-select words, one for interrupts, one for branches and one for waits. It hands all of these to a separate descriptor sequencer. That sequencer reports back through single-cycle event inputs: kill, stop, descriptor fetch, branch-taken set and clear, interrupt raise, and command-pointer update. Toward the sequencer, the block pulses a kick when the channel becomes active and a fetch request when software loads a new command pointer. It also holds a flush request to the data path until that path acknowledges it.

Control writes go through a two-state machine. In `ST_IDLE`, a control write that needs no flush commits on the same edge and stays in `ST_IDLE`. A control write that needs a flush takes the transition `ST_IDLE -> ST_FLUSH` and holds the computed result as pending. On `flush_ack` the machine takes the transition `ST_FLUSH -> ST_IDLE` and commits the pending result. While in `ST_FLUSH`, further control writes are dropped.

Top module: `dbc_chan_ctl`

## Requirements
- R1: After reset every offset reads zero and `kick`, `fetch_req`, `flush_req`, `ctl_busy`, `irq`, `run_o`, `pause_o`, `active_o` and `cmd_ptr` are zero.
- R2: The status word places run at bit 0, pause 1, flush 2, wake 3, dead 4, active 5 and branch-taken 6; all higher bits read zero. A control write (offset 0) changes run or pause only where the matching mask bit (bit 16 + n) is 1. Mask bits for dead, active and branch-taken have no effect.
- R3: After a control write, active is 0 if pause is 1 or run is 0. Otherwise active becomes 1 if run or pause was masked, or if wake was written 1. In any other case active is unchanged.
- R4: Wake is set only when a masked wake-1 write leaves run at 1. A `seq_fetch` pulse clears wake.
- R5: A control write that writes flush 1, or that leaves pause 1 or run 0, enters `ST_FLUSH`. In that state `flush_req` and `ctl_busy` are 1 until `flush_ack`, and the status shows flush = 1 only if flush was written. The new run, pause, wake and active values appear in the cycle after `flush_ack`, with flush back at 0. Control writes made while busy are ignored.
- R6: A control write that masks run with value 0 clears dead.
- R7: Offsets 0 and 1 both read the status word, and writes to offset 1 are ignored.
- R8: A write to the command pointer (offset 2) is ignored while active is 1. An accepted write stores the value with its low 4 bits zero and pulses `fetch_req` for the following cycle.
- R9: `kick` is high for exactly the cycle after a control commit that leaves active at 1.
- R10: `seq_kill` sets dead, clears active and raises `irq`. `seq_stop` clears active. `seq_bt_set` and `seq_bt_clr` set and clear branch-taken. `seq_ptr_we` loads the command pointer with its low 4 bits zero.
- R11: Offset 7 bit 0 reads the interrupt flag. Writing 1 to it clears the flag, but a `seq_kill` or `seq_irq` in the same cycle wins.
- R12: Offsets 4, 5 and 6 read back the interrupt, branch and wait select words, which also drive `isel`, `bsel` and `wsel`. Offset 3 and offsets 8 to 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| ctl_busy | output | 1 | Control write waiting for a flush to finish |
| flush_req | output | 1 | Flush request to the data path |
| flush_ack | input | 1 | Flush finished |
| kick | output | 1 | One-cycle pulse: the channel became active |
| fetch_req | output | 1 | One-cycle pulse: fetch the descriptor at `cmd_ptr` |
| run_o | output | 1 | Run bit |
| pause_o | output | 1 | Pause bit |
| active_o | output | 1 | Active bit |
| cmd_ptr | output | DATA_W | Command pointer |
| isel | output | DATA_W | Interrupt condition select |
| bsel | output | DATA_W | Branch condition select |
| wsel | output | DATA_W | Wait condition select |
| seq_kill | input | 1 | Sequencer: kill the channel |
| seq_stop | input | 1 | Sequencer: stop command reached |
| seq_fetch | input | 1 | Sequencer: descriptor fetched |
| seq_bt_set | input | 1 | Sequencer: branch taken |
| seq_bt_clr | input | 1 | Sequencer: sequential step |
| seq_irq | input | 1 | Sequencer: raise interrupt |
| seq_ptr_we | input | 1 | Sequencer: load command pointer |
| seq_ptr_val | input | DATA_W | Sequencer command pointer value |
| irq | output | 1 | Interrupt flag |

## Verification
A wrong pending result or a wrong state transition shows on the ports in the cycle after the commit edge. It appears as a status word that differs from the mask rules, a missing or spurious `kick`, or a `ctl_busy` that stays high after `flush_ack`. A broken write lock on the command pointer shows as a `fetch_req` pulse, or a changed pointer read, in the cycle after the rejected write. Random control words cover many mask and value combinations. Directed cases cover collisions between software and the sequencer.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    // Register word offsets
    localparam int REG_CTRL  = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_PTR   = 2;
    localparam int REG_PTRHI = 3;
    localparam int REG_ISEL  = 4;
    localparam int REG_BSEL  = 5;
    localparam int REG_WSEL  = 6;
    localparam int REG_IRQ   = 7;

    // Status word, bit 0 = run ... bit 6 = branch taken
    typedef struct packed {
        logic bt;
        logic active;
        logic dead;
        logic wake;
        logic flush;
        logic pause;
        logic run;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } ctl_state_e;

    typedef struct packed {
        stat_t nxt;
        logic  need_flush;
        logic  flush_bit;
    } ctl_res_t;

    // Apply one masked control word to the current status
    function automatic ctl_res_t ctl_apply(stat_t cur, stat_t msk, stat_t val);
        ctl_res_t r;
        r.nxt        = cur;
        r.need_flush = 1'b0;
        r.flush_bit  = 1'b0;
        if (msk.run) begin
            r.nxt.run = val.run;
            if (!val.run) begin
                r.nxt.dead = 1'b0;
            end
        end
        if (msk.wake && val.wake && r.nxt.run) begin
            r.nxt.wake = 1'b1;
        end
        if (msk.pause) begin
            r.nxt.pause = val.pause;
        end
        if (msk.flush && val.flush) begin
            r.need_flush = 1'b1;
            r.flush_bit  = 1'b1;
        end
        if (r.nxt.pause || !r.nxt.run) begin
            r.nxt.active = 1'b0;
            r.need_flush = 1'b1;
        end else if (msk.run || msk.pause) begin
            r.nxt.active = 1'b1;
        end else if (msk.wake && val.wake) begin
            r.nxt.active = 1'b1;
        end
        r.nxt.flush = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/dbc_ctl_fsm.sv
module dbc_ctl_fsm
    import dbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_we,
    input  stat_t ctl_msk,
    input  stat_t ctl_val,
    input  stat_t cur,
    input  logic  seq_kill,
    input  logic  flush_ack,
    output logic  commit,
    output stat_t commit_stat,
    output logic  dead_clr,
    output logic  flush_mark,
    output logic  flush_req,
    output logic  busy
);

    ctl_state_e state;
    stat_t      pend_stat;
    logic       pend_dclr;
    ctl_res_t   res;
    logic       now_dclr;

    assign res      = ctl_apply(cur, ctl_msk, ctl_val);
    assign now_dclr = ctl_msk.run && !ctl_val.run;

    // State register and pending result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_stat <= '0;
            pend_dclr <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ctrl_we && res.need_flush) begin
                        state     <= ST_FLUSH;
                        pend_stat <= res.nxt;
                        pend_dclr <= now_dclr;
                    end
                end
                ST_FLUSH: begin
                    if (seq_kill) begin
                        pend_stat.active <= 1'b0;
                    end
                    if (flush_ack) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit      = 1'b0;
        commit_stat = res.nxt;
        dead_clr    = now_dclr;
        flush_mark  = 1'b0;
        flush_req   = 1'b0;
        busy        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                commit     = ctrl_we && !res.need_flush;
                flush_mark = ctrl_we && res.need_flush && res.flush_bit;
            end
            ST_FLUSH: begin
                commit      = flush_ack;
                commit_stat = pend_stat;
                dead_clr    = pend_dclr;
                flush_req   = 1'b1;
                busy        = 1'b1;
            end
            default: begin
                commit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbc_status.sv
module dbc_status
    import dbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  commit,
    input  stat_t commit_stat,
    input  logic  dead_clr,
    input  logic  flush_mark,
    input  logic  seq_kill,
    input  logic  seq_stop,
    input  logic  seq_fetch,
    input  logic  seq_bt_set,
    input  logic  seq_bt_clr,
    input  logic  seq_irq,
    input  logic  irq_clr,
    output stat_t stat,
    output logic  kick,
    output logic  irq
);

    stat_t nxt;
    logic  irq_nxt;

    always_comb begin
        nxt = stat;
        if (flush_mark) begin
            nxt.flush = 1'b1;
        end
        if (commit) begin
            nxt.run    = commit_stat.run;
            nxt.pause  = commit_stat.pause;
            nxt.wake   = commit_stat.wake;
            nxt.active = commit_stat.active;
            nxt.flush  = 1'b0;
            if (dead_clr) begin
                nxt.dead = 1'b0;
            end
        end
        if (seq_fetch) begin
            nxt.wake = 1'b0;
        end
        if (seq_bt_set) begin
            nxt.bt = 1'b1;
        end
        if (seq_bt_clr) begin
            nxt.bt = 1'b0;
        end
        if (seq_stop) begin
            nxt.active = 1'b0;
        end
        if (seq_kill) begin
            nxt.dead   = 1'b1;
            nxt.active = 1'b0;
        end
    end

    always_comb begin
        irq_nxt = irq;
        if (irq_clr) begin
            irq_nxt = 1'b0;
        end
        if (seq_kill || seq_irq) begin
            irq_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            kick <= 1'b0;
            irq  <= 1'b0;
        end else begin
            stat <= nxt;
            kick <= commit && nxt.active;
            irq  <= irq_nxt;
        end
    end

endmodule

// File: rtl/dbc_regs.sv
module dbc_regs
    import dbc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int PTR_ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  stat_t             stat,
    input  logic              irq,
    input  logic              seq_ptr_we,
    input  logic [DATA_W-1:0] seq_ptr_val,
    output logic [DATA_W-1:0] cmd_ptr,
    output logic [DATA_W-1:0] isel,
    output logic [DATA_W-1:0] bsel,
    output logic [DATA_W-1:0] wsel,
    output logic              fetch_req,
    output logic [DATA_W-1:0] rdata,
    output logic              ctrl_we,
    output logic              irq_clr
);

    localparam logic [DATA_W-1:0] PTR_MASK = ~((DATA_W'(1) << PTR_ALIGN) - DATA_W'(1));

    logic ptr_we;

    assign ctrl_we = reg_we && (reg_addr == ADDR_W'(REG_CTRL));
    assign irq_clr = reg_we && (reg_addr == ADDR_W'(REG_IRQ)) && reg_wdata[0];
    assign ptr_we  = reg_we && (reg_addr == ADDR_W'(REG_PTR)) && !stat.active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ptr   <= '0;
            isel      <= '0;
            bsel      <= '0;
            wsel      <= '0;
            fetch_req <= 1'b0;
        end else begin
            fetch_req <= ptr_we;
            if (seq_ptr_we) begin
                cmd_ptr <= seq_ptr_val & PTR_MASK;
            end else if (ptr_we) begin
                cmd_ptr <= reg_wdata & PTR_MASK;
            end
            if (reg_we && reg_addr == ADDR_W'(REG_ISEL)) begin
                isel <= reg_wdata;
            end
            if (reg_we && reg_addr == ADDR_W'(REG_BSEL)) begin
                bsel <= reg_wdata;
            end
            if (reg_we && reg_addr == ADDR_W'(REG_WSEL)) begin
                wsel <= reg_wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr)
            ADDR_W'(REG_CTRL),
            ADDR_W'(REG_STAT): rdata[STAT_W-1:0] = stat;
            ADDR_W'(REG_PTR):  rdata = cmd_ptr;
            ADDR_W'(REG_ISEL): rdata = isel;
            ADDR_W'(REG_BSEL): rdata = bsel;
            ADDR_W'(REG_WSEL): rdata = wsel;
            ADDR_W'(REG_IRQ):  rdata[0] = irq;
            default:           rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbc_chan_ctl.sv
module dbc_chan_ctl
    import dbc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int PTR_ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ctl_busy,
    output logic              flush_req,
    input  logic              flush_ack,
    output logic              kick,
    output logic              fetch_req,
    output logic              run_o,
    output logic              pause_o,
    output logic              active_o,
    output logic [DATA_W-1:0] cmd_ptr,
    output logic [DATA_W-1:0] isel,
    output logic [DATA_W-1:0] bsel,
    output logic [DATA_W-1:0] wsel,
    input  logic              seq_kill,
    input  logic              seq_stop,
    input  logic              seq_fetch,
    input  logic              seq_bt_set,
    input  logic              seq_bt_clr,
    input  logic              seq_irq,
    input  logic              seq_ptr_we,
    input  logic [DATA_W-1:0] seq_ptr_val,
    output logic              irq
);

    localparam int HALF = DATA_W / 2;

    stat_t stat;
    stat_t ctl_msk;
    stat_t ctl_val;
    stat_t commit_stat;
    logic  ctrl_we;
    logic  irq_clr;
    logic  commit;
    logic  dead_clr;
    logic  flush_mark;

    assign ctl_msk = stat_t'(reg_wdata[HALF +: STAT_W]);
    assign ctl_val = stat_t'(reg_wdata[0 +: STAT_W]);

    dbc_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .PTR_ALIGN (PTR_ALIGN)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .stat        (stat),
        .irq         (irq),
        .seq_ptr_we  (seq_ptr_we),
        .seq_ptr_val (seq_ptr_val),
        .cmd_ptr     (cmd_ptr),
        .isel        (isel),
        .bsel        (bsel),
        .wsel        (wsel),
        .fetch_req   (fetch_req),
        .rdata       (reg_rdata),
        .ctrl_we     (ctrl_we),
        .irq_clr     (irq_clr)
    );

    dbc_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctl_msk     (ctl_msk),
        .ctl_val     (ctl_val),
        .cur         (stat),
        .seq_kill    (seq_kill),
        .flush_ack   (flush_ack),
        .commit      (commit),
        .commit_stat (commit_stat),
        .dead_clr    (dead_clr),
        .flush_mark  (flush_mark),
        .flush_req   (flush_req),
        .busy        (ctl_busy)
    );

    dbc_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_stat (commit_stat),
        .dead_clr    (dead_clr),
        .flush_mark  (flush_mark),
        .seq_kill    (seq_kill),
        .seq_stop    (seq_stop),
        .seq_fetch   (seq_fetch),
        .seq_bt_set  (seq_bt_set),
        .seq_bt_clr  (seq_bt_clr),
        .seq_irq     (seq_irq),
        .irq_clr     (irq_clr),
        .stat        (stat),
        .kick        (kick),
        .irq         (irq)
    );

    always_comb begin
        run_o    = stat.run;
        pause_o  = stat.pause;
        active_o = stat.active;
    end

endmodule

// File: rtl/dbc_chan_ctl_chk.sv
module dbc_chan_ctl_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              flush_req,
    input logic              flush_ack,
    input logic              kick,
    input logic              fetch_req,
    input logic              run_o,
    input logic              pause_o,
    input logic              active_o,
    input logic [DATA_W-1:0] cmd_ptr,
    input logic              seq_kill,
    input logic              seq_ptr_we,
    input logic              irq
);

    AST_STOPPED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_o || !run_o) |-> !active_o); // R3

    AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req); // R5

    AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && reg_we && reg_addr == ADDR_W'(2) && !seq_ptr_we) |=> $stable(cmd_ptr)); // R8

    AST_FETCH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> $past(reg_we && reg_addr == ADDR_W'(2) && !active_o)); // R8

    AST_KICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> active_o); // R9

    AST_KILL_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        seq_kill |=> (!active_o && irq)); // R10

endmodule

bind dbc_chan_ctl dbc_chan_ctl_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .flush_req  (flush_req),
    .flush_ack  (flush_ack),
    .kick       (kick),
    .fetch_req  (fetch_req),
    .run_o      (run_o),
    .pause_o    (pause_o),
    .active_o   (active_o),
    .cmd_ptr    (cmd_ptr),
    .seq_kill   (seq_kill),
    .seq_ptr_we (seq_ptr_we),
    .irq        (irq)
);

// File: tb/dbc_chan_ctl_tb.sv
`timescale 1ns/1ps
module dbc_chan_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ctl_busy, flush_req, kick, fetch_req, run_o, pause_o, active_o, irq;
    logic        flush_ack = 1'b0;
    logic [31:0] cmd_ptr, isel, bsel, wsel;
    logic        seq_kill = 0, seq_stop = 0, seq_fetch = 0, seq_bt_set = 0, seq_bt_clr = 0;
    logic        seq_irq = 0, seq_ptr_we = 0;
    logic [31:0] seq_ptr_val = '0;

    int checks = 0;
    int failures = 0;

    logic [6:0]  m_stat = '0;
    logic [31:0] m_ptr = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_sel [3];

    always #2.5 clk = ~clk;

    dbc_chan_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_busy(ctl_busy),
        .flush_req(flush_req), .flush_ack(flush_ack), .kick(kick),
        .fetch_req(fetch_req), .run_o(run_o), .pause_o(pause_o),
        .active_o(active_o), .cmd_ptr(cmd_ptr), .isel(isel), .bsel(bsel),
        .wsel(wsel), .seq_kill(seq_kill), .seq_stop(seq_stop),
        .seq_fetch(seq_fetch), .seq_bt_set(seq_bt_set), .seq_bt_clr(seq_bt_clr),
        .seq_irq(seq_irq), .seq_ptr_we(seq_ptr_we), .seq_ptr_val(seq_ptr_val),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result of a control word: {flush_written, needs_flush, status}
    function automatic logic [8:0] model_ctl(input logic [6:0] s, input logic [6:0] m,
                                             input logic [6:0] v);
        logic run, pause, wake, dead, act, stopped, fl;
        run     = m[0] ? v[0] : s[0];
        pause   = m[1] ? v[1] : s[1];
        dead    = (m[0] && !v[0]) ? 1'b0 : s[4];
        wake    = s[3] | (m[3] & v[3] & run);
        stopped = pause | ~run;
        if (stopped)                        act = 1'b0;
        else if (m[0] | m[1] | (m[3] & v[3])) act = 1'b1;
        else                                act = s[5];
        fl = m[2] & v[2];
        return {fl, fl | stopped, s[6], act, dead, wake, 1'b0, pause, run};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_ctl(input logic [6:0] m, input logic [6:0] v);
        logic [8:0]  r;
        logic [31:0] d;
        r = model_ctl(m_stat, m, v);
        wr(4'd0, {9'b0, m, 9'b0, v});
        if (r[7]) begin
            chk("R5 busy in flush", {31'b0, ctl_busy}, 32'd1);
            chk("R5 flush_req in flush", {31'b0, flush_req}, 32'd1);
            rd(4'd1, d);
            chk("R5 flush bit while flushing", d, {25'b0, m_stat | {4'b0, r[8], 2'b0}});
            repeat ($urandom_range(0, 3)) @(negedge clk);
            flush_ack = 1'b1;
            @(negedge clk);
            flush_ack = 1'b0;
            chk("R5 busy cleared", {31'b0, ctl_busy}, 32'd0);
        end
        chk("R9 kick", {31'b0, kick}, {31'b0, r[5]});
        m_stat = r[6:0];
        rd(4'd0, d);
        chk("R2 R3 R4 R6 status after control", d, {25'b0, m_stat});
        chk("R3 active_o", {31'b0, active_o}, {31'b0, m_stat[5]});
    endtask

    task automatic do_ptr(input logic [31:0] d);
        logic        ok;
        logic [31:0] q;
        ok = !m_stat[5];
        wr(4'd2, d);
        chk("R8 fetch_req", {31'b0, fetch_req}, {31'b0, ok});
        if (ok) m_ptr = d & 32'hFFFF_FFF0;
        rd(4'd2, q);
        chk("R8 command pointer", q, m_ptr);
    endtask

    task automatic do_seq(input int kind);
        logic [31:0] d;
        logic [31:0] pv;
        pv = $urandom;
        case (kind)
            0: seq_kill = 1'b1;
            1: seq_stop = 1'b1;
            2: seq_fetch = 1'b1;
            3: seq_bt_set = 1'b1;
            4: seq_bt_clr = 1'b1;
            5: seq_irq = 1'b1;
            default: begin seq_ptr_we = 1'b1; seq_ptr_val = pv; end
        endcase
        @(negedge clk);
        {seq_kill, seq_stop, seq_fetch, seq_bt_set, seq_bt_clr, seq_irq, seq_ptr_we} = '0;
        case (kind)
            0: begin m_stat[4] = 1'b1; m_stat[5] = 1'b0; m_irq = 1'b1; end
            1: m_stat[5] = 1'b0;
            2: m_stat[3] = 1'b0;
            3: m_stat[6] = 1'b1;
            4: m_stat[6] = 1'b0;
            5: m_irq = 1'b1;
            default: m_ptr = pv & 32'hFFFF_FFF0;
        endcase
        rd(4'd1, d);
        chk("R10 status after sequencer event", d, {25'b0, m_stat});
        chk("R10 irq after sequencer event", {31'b0, irq}, {31'b0, m_irq});
        chk("R10 pointer after sequencer event", cmd_ptr, m_ptr);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_sel[0] = '0; m_sel[1] = '0; m_sel[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], d);
            chk("R1 reset read", d, 32'd0);
        end
        chk("R1 reset outputs",
            {24'b0, kick, fetch_req, flush_req, ctl_busy, irq, run_o, pause_o, active_o}, 32'd0);
        chk("R1 reset pointer", cmd_ptr, 32'd0);

        // R8 accepted pointer write while idle
        do_ptr(32'h1234_567F);
        // R3 R9 start the channel
        do_ctl(7'h01, 7'h01);
        // R8 pointer locked while active
        do_ptr(32'hDEAD_BEE0);
        // R2 masked-off hardware bits ignored
        do_ctl(7'h70, 7'h70);
        // R7 status writes ignored
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, d);
        chk("R7 status write ignored", d, {25'b0, m_stat});
        // R4 wake while running, cleared by fetch
        do_ctl(7'h08, 7'h08);
        do_seq(2);

        // R5 control write while busy is ignored
        wr(4'd0, {9'b0, 7'h04, 9'b0, 7'h04});
        chk("R5 busy after flush write", {31'b0, ctl_busy}, 32'd1);
        wr(4'd0, {9'b0, 7'h02, 9'b0, 7'h02});
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
        rd(4'd0, d);
        chk("R5 write during busy ignored", d, {25'b0, m_stat});

        // R6 kill then run=0 clears dead
        do_seq(0);
        do_ctl(7'h01, 7'h00);

        // R11 set wins over clear in same cycle, then clear alone
        reg_we = 1'b1; reg_addr = 4'd7; reg_wdata = 32'd1; seq_irq = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; seq_irq = 1'b0;
        chk("R11 set beats clear", {31'b0, irq}, 32'd1);
        wr(4'd7, 32'd1);
        m_irq = 1'b0;
        rd(4'd7, d);
        chk("R11 write one clears", d, 32'd0);

        // R12 high pointer and unmapped offsets
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d);
        chk("R12 high pointer reads zero", d, 32'd0);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, d);
        chk("R12 unmapped reads zero", d, 32'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 19);
            if (op < 10) begin
                do_ctl(7'($urandom), 7'($urandom));
            end else if (op < 13) begin
                do_ptr($urandom);
            end else if (op < 17) begin
                do_seq($urandom_range(0, 6));
            end else if (op == 17) begin
                wr(4'd7, 32'($urandom_range(0, 1)));
                if (reg_wdata[0]) m_irq = 1'b0;
                rd(4'd7, d);
                chk("R11 irq register", d, {31'b0, m_irq});
            end else if (op == 18) begin
                int k;
                logic [31:0] v;
                k = $urandom_range(0, 2);
                v = $urandom;
                wr(4'(4 + k), v);
                m_sel[k] = v;
                rd(4'(4 + k), d);
                chk("R12 select readback", d, m_sel[k]);
                chk("R12 select ports", k == 0 ? isel : (k == 1 ? bsel : wsel), m_sel[k]);
            end else begin
                wr(4'd1, $urandom);
                rd(4'd1, d);
                chk("R7 status write ignored", d, {25'b0, m_stat});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule